// File: doc/BRIEF.md
# Programmable GPIO Input Debounce Filter

This block conditions one general-purpose input pin. The asynchronous pad level first passes through a two-flop synchroniser. A small state machine then decides when the filtered output may follow the synchronised level. The filter window is a 4-bit count multiplied by a tick length. A 2-bit timebase select picks the tick length as 2, 8, 512 or 2048 strobes of a slow real-time clock. The system clock runs the whole block. A single-cycle enable strobe marks each real-time clock period, and a prescaler turns those strobes into ticks.

A 2-bit mode chooses the filter policy. Pass-through ignores the timer. Full rejection requires a new level of either polarity to persist for the whole window. The two one-sided modes let edges toward one level through at once and filter only edges toward the other level. A one-sided mode suits a level-sensitive interrupt whose active level is the opposite of the level it lets through unfiltered. A count of zero means that no filter time is programmed, and the input then passes straight through in every mode. The configuration fields are treated as static register values.

The state machine has two states. SETTLED means the output equals the synchronised level, or a change is applied at once. QUALIFY means a candidate level is being timed. Its transitions are:
- START: SETTLED to QUALIFY on a mismatch that must be filtered.
- ABORT: QUALIFY to SETTLED when the level reverts.
- COMMIT: QUALIFY to SETTLED when the window completes.
- BYPASS: QUALIFY to SETTLED when the mismatch becomes one that passes at once.

Top module: `gpio_debounce`

## Requirements
- R1: While reset is asserted and on its release, `filt_out` is 0 whatever the pad does, and the window timer is empty.
- R2: With `cfg_mode` = 2'b00 (pass-through), `filt_out` takes the pad level on the third rising clock edge after the pad changes: two synchroniser flops, then the output register. Pulses of any length pass.
- R3: With `cfg_count` = 0, every mode behaves as pass-through, with the same three-edge latency.
- R4: With `cfg_mode` = 2'b11 (full rejection), a new level reaches `filt_out` only after it has been present for N = `cfg_count` x tick strobes. With the strobe high every cycle, the output changes 3 + N edges after the pad changes.
- R5: In full rejection, a pulse of either polarity shorter than the window never appears on `filt_out`.
- R6: Any reversal of the synchronised level during QUALIFY aborts the window, and a later change starts a fresh window. If the reversal falls in the very cycle the window would complete, the reversal wins.
- R7: The tick length comes from `cfg_tsel` = {large, unit}: 2'b00 gives 2 strobes, 2'b01 gives 8, 2'b10 gives 512 and 2'b11 gives 2048.
- R8: With `cfg_mode` = 2'b01 (keep-low), a fall reaches `filt_out` with pass-through latency, and a rise is filtered as in R4.
- R9: With `cfg_mode` = 2'b10 (keep-high), a rise reaches `filt_out` with pass-through latency, and a fall is filtered as in R4.
- R10: The window advances only on cycles with `rtc_en` high. While `rtc_en` is low, a filtered change stays pending for any length of time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rtc_en | input | 1 | One-cycle strobe per real-time clock period |
| pad_in | input | 1 | Asynchronous pad level |
| cfg_count | input | CNT_W | Window length in ticks, where 0 means no filtering |
| cfg_tsel | input | 2 | Tick length select {large, unit} |
| cfg_mode | input | 2 | 00 pass, 01 keep-low, 10 keep-high, 11 full rejection |
| filt_out | output | 1 | Filtered level |

## Verification
Two events can fall in the same clock edge: the strobe that would complete the window (COMMIT) and the reversal of the synchronised level (ABORT). The bench provokes this with a full-rejection pulse that lasts exactly N cycles, so the reversal reaches the state machine on the edge that would deliver the last strobe. It expects the output to stay low. A companion pulse one cycle longer must commit and then fall back after a second window. The scoreboard holds the expected level on the edge before and the edge of every predicted change, so an off-by-one in either the prescaler or the tick counter is reported.

// File: rtl/dbn_pkg.sv
package dbn_pkg;

    typedef enum logic [1:0] {
        FM_PASS      = 2'b00,
        FM_KEEP_LOW  = 2'b01,
        FM_KEEP_HIGH = 2'b10,
        FM_REJECT    = 2'b11
    } filt_mode_e;

    typedef enum logic {
        DS_SETTLED = 1'b0,
        DS_QUALIFY = 1'b1
    } dbn_state_e;

endpackage

// File: rtl/dbn_sync.sv
module dbn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[0] <= 1'b0;
        else        pipe[0] <= din;
    end

    for (genvar i = 1; i < STAGES; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe[i] <= 1'b0;
            else        pipe[i] <= pipe[i-1];
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/dbn_prescale.sv
module dbn_prescale #(
    parameter int TICK_S  = 2,
    parameter int TICK_M  = 8,
    parameter int TICK_L  = 512,
    parameter int TICK_XL = 2048
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hold_clr,
    input  logic       rtc_en,
    input  logic [1:0] tsel,
    output logic       tick
);
    localparam int PRE_W = (TICK_XL > 2) ? $clog2(TICK_XL) : 1;

    logic [PRE_W-1:0] cnt;
    logic [PRE_W-1:0] last;

    always_comb begin
        unique case (tsel)
            2'b00:   last = PRE_W'(TICK_S - 1);
            2'b01:   last = PRE_W'(TICK_M - 1);
            2'b10:   last = PRE_W'(TICK_L - 1);
            default: last = PRE_W'(TICK_XL - 1);
        endcase
    end

    assign tick = rtc_en && !hold_clr && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt <= '0;
        else if (hold_clr) cnt <= '0;
        else if (rtc_en)   cnt <= (cnt == last) ? '0 : cnt + 1'b1;
    end
endmodule

// File: rtl/dbn_fsm.sv
module dbn_fsm
    import dbn_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lvl,
    input  filt_mode_e       mode,
    input  logic [CNT_W-1:0] count,
    input  logic             tick,
    output logic             timer_clr,
    output logic             level_q
);
    dbn_state_e       state, nxt;
    logic [CNT_W-1:0] tick_cnt;
    logic             take;
    logic             mismatch;
    logic             instant;
    logic             window_done;

    assign mismatch    = (lvl != level_q);
    assign instant     = (mode == FM_PASS) || (count == '0) ||
                         ((mode == FM_KEEP_LOW)  && !lvl) ||
                         ((mode == FM_KEEP_HIGH) &&  lvl);
    assign window_done = tick && (tick_cnt == count - CNT_W'(1));
    assign timer_clr   = (state == DS_SETTLED);

    always_comb begin
        nxt  = state;
        take = 1'b0;
        unique case (state)
            DS_SETTLED: begin
                if (mismatch) begin
                    if (instant) take = 1'b1;
                    else         nxt  = DS_QUALIFY;
                end
            end
            DS_QUALIFY: begin
                if (!mismatch) begin
                    nxt = DS_SETTLED;
                end else if (instant || window_done) begin
                    take = 1'b1;
                    nxt  = DS_SETTLED;
                end
            end
            default: nxt = DS_SETTLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= DS_SETTLED;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= 1'b0;
            tick_cnt <= '0;
        end else begin
            if (take) level_q <= lvl;
            if (state == DS_SETTLED) tick_cnt <= '0;
            else if (tick)           tick_cnt <= tick_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/gpio_debounce.sv
module gpio_debounce
    import dbn_pkg::*;
#(
    parameter int CNT_W       = 4,
    parameter int SYNC_STAGES = 2,
    parameter int TICK_S      = 2,
    parameter int TICK_M      = 8,
    parameter int TICK_L      = 512,
    parameter int TICK_XL     = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_en,
    input  logic             pad_in,
    input  logic [CNT_W-1:0] cfg_count,
    input  logic [1:0]       cfg_tsel,
    input  logic [1:0]       cfg_mode,
    output logic             filt_out
);
    logic       sync_lvl;
    logic       tick;
    logic       timer_clr;
    filt_mode_e mode_e;

    assign mode_e = filt_mode_e'(cfg_mode);

    dbn_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (sync_lvl)
    );

    dbn_prescale #(
        .TICK_S (TICK_S),
        .TICK_M (TICK_M),
        .TICK_L (TICK_L),
        .TICK_XL(TICK_XL)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_clr(timer_clr),
        .rtc_en  (rtc_en),
        .tsel    (cfg_tsel),
        .tick    (tick)
    );

    dbn_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (sync_lvl),
        .mode     (mode_e),
        .count    (cfg_count),
        .tick     (tick),
        .timer_clr(timer_clr),
        .level_q  (filt_out)
    );
endmodule

// File: rtl/dbn_chk.sv
module dbn_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rtc_en,
    input logic [CNT_W-1:0] cfg_count,
    input logic [1:0]       cfg_mode,
    input logic             sync_lvl,
    input logic             filt_out
);
    always @(posedge clk) begin
        if (!rst_n) p_reset_low_r1: assert (!filt_out);
    end

    p_pass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'b00) |=> (filt_out == $past(sync_lvl)));

    p_zero_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_count == '0) |=> (filt_out == $past(sync_lvl)));

    p_hold_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'b11) && (cfg_count != '0) && !rtc_en) |=> $stable(filt_out));

    p_fall_now_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'b01) && filt_out && !sync_lvl) |=> !filt_out);

    p_rise_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'b01) && (cfg_count != '0) && !rtc_en) |=> !$rose(filt_out));

    p_rise_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((cfg_mode == 2'b10) && !filt_out && sync_lvl) |=> filt_out);
endmodule

bind gpio_debounce dbn_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rtc_en   (rtc_en),
    .cfg_count(cfg_count),
    .cfg_mode (cfg_mode),
    .sync_lvl (sync_lvl),
    .filt_out (filt_out)
);

// File: tb/tb_gpio_debounce.sv
module tb_gpio_debounce;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rtc_en = 1'b1;
    logic       pad_in = 1'b0;
    logic [3:0] cfg_count = 4'd0;
    logic [1:0] cfg_tsel = 2'b00;
    logic [1:0] cfg_mode = 2'b00;
    logic       filt_out;

    int  cyc = 0;
    int  checks = 0;
    int  errors = 0;
    bit  finished = 1'b0;

    typedef struct {
        int    at;
        logic  val;
        string req;
    } exp_t;

    exp_t sb[$];

    gpio_debounce dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .rtc_en   (rtc_en),
        .pad_in   (pad_in),
        .cfg_count(cfg_count),
        .cfg_tsel (cfg_tsel),
        .cfg_mode (cfg_mode),
        .filt_out (filt_out)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // monitor: compares the output against queued expectations
    always @(negedge clk) begin
        while (sb.size() > 0 && sb[0].at <= cyc) begin
            checks++;
            if (sb[0].at < cyc) begin
                errors++;
                $display("FAIL %s: expectation for cycle %0d missed (now %0d)",
                         sb[0].req, sb[0].at, cyc);
            end else if (filt_out !== sb[0].val) begin
                errors++;
                $display("FAIL %s: cycle %0d filt_out=%b expected %b",
                         sb[0].req, cyc, filt_out, sb[0].val);
            end
            void'(sb.pop_front());
        end
    end

    task automatic expect_at(input int at, input logic v, input string r);
        exp_t e;
        e.at = at; e.val = v; e.req = r;
        sb.push_back(e);
    endtask

    task automatic wait_to(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic drain;
        while (sb.size() > 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic set_cfg(input logic [1:0] m, input logic [3:0] n, input logic [1:0] ts);
        cfg_mode = m; cfg_count = n; cfg_tsel = ts;
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not finish, cycle %0d expected end", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int b;
        // R1: reset holds output low with pad high
        pad_in = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            checks++;
            if (filt_out !== 1'b0) begin
                errors++;
                $display("FAIL R1: during reset filt_out=%b expected 0", filt_out);
            end
        end
        pad_in = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        b = cyc;
        expect_at(b + 1, 1'b0, "R1");
        expect_at(b + 4, 1'b0, "R1");
        drain();

        // R2: pass-through, count ignored
        set_cfg(2'b00, 4'd5, 2'b00);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 2, 1'b0, "R2");  expect_at(b + 3, 1'b1, "R2");
        expect_at(b + 12, 1'b1, "R2"); expect_at(b + 13, 1'b0, "R2");
        expect_at(b + 23, 1'b1, "R2"); expect_at(b + 24, 1'b0, "R2");
        wait_to(b + 10); pad_in = 1'b0;
        wait_to(b + 20); pad_in = 1'b1;
        wait_to(b + 21); pad_in = 1'b0;
        drain();

        // R3: count zero in full rejection mode
        set_cfg(2'b11, 4'd0, 2'b00);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 2, 1'b0, "R3");  expect_at(b + 3, 1'b1, "R3");
        expect_at(b + 12, 1'b1, "R3"); expect_at(b + 13, 1'b0, "R3");
        wait_to(b + 10); pad_in = 1'b0;
        drain();

        // R4: full rejection, count 15, tick 2 -> N = 30
        set_cfg(2'b11, 4'd15, 2'b00);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 32, 1'b0, "R4"); expect_at(b + 33, 1'b1, "R4");
        expect_at(b + 72, 1'b1, "R4"); expect_at(b + 73, 1'b0, "R4");
        wait_to(b + 40); pad_in = 1'b0;
        drain();

        // R5: short pulses of both polarities rejected, N = 6
        set_cfg(2'b11, 4'd3, 2'b00);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 3, 1'b0, "R5");  expect_at(b + 6, 1'b0, "R5");
        expect_at(b + 9, 1'b0, "R5");  expect_at(b + 15, 1'b0, "R5");
        expect_at(b + 28, 1'b0, "R4"); expect_at(b + 29, 1'b1, "R4");
        expect_at(b + 45, 1'b1, "R5"); expect_at(b + 50, 1'b1, "R5");
        expect_at(b + 55, 1'b1, "R5");
        wait_to(b + 5);  pad_in = 1'b0;
        wait_to(b + 20); pad_in = 1'b1;
        wait_to(b + 40); pad_in = 1'b0;
        wait_to(b + 45); pad_in = 1'b1;
        drain();

        // R6: reversal restarts the window
        b = cyc;
        pad_in = 1'b0;
        expect_at(b + 12, 1'b1, "R6"); expect_at(b + 13, 1'b0, "R6");
        wait_to(b + 3); pad_in = 1'b1;
        wait_to(b + 4); pad_in = 1'b0;
        drain();

        // R6: reversal on the completing edge wins (N = 2)
        set_cfg(2'b11, 4'd1, 2'b00);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 5, 1'b0, "R6"); expect_at(b + 6, 1'b0, "R6");
        expect_at(b + 8, 1'b0, "R6");
        wait_to(b + 2); pad_in = 1'b0;
        drain();
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 4, 1'b0, "R6"); expect_at(b + 5, 1'b1, "R6");
        expect_at(b + 7, 1'b1, "R6"); expect_at(b + 8, 1'b0, "R6");
        wait_to(b + 3); pad_in = 1'b0;
        drain();

        // R7: tick lengths 8, 512, 2048
        set_cfg(2'b11, 4'd3, 2'b01);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 26, 1'b0, "R7"); expect_at(b + 27, 1'b1, "R7");
        drain();
        set_cfg(2'b11, 4'd1, 2'b10);
        b = cyc;
        pad_in = 1'b0;
        expect_at(b + 514, 1'b1, "R7"); expect_at(b + 515, 1'b0, "R7");
        drain();
        set_cfg(2'b11, 4'd1, 2'b11);
        b = cyc;
        pad_in = 1'b1;
        expect_at(b + 2050, 1'b0, "R7"); expect_at(b + 2051, 1'b1, "R7");
        drain();

        // R8: keep-low, N = 6
        set_cfg(2'b01, 4'd3, 2'b00);
        b = cyc;
        pad_in = 1'b0;
        expect_at(b + 2, 1'b1, "R8");  expect_at(b + 3, 1'b0, "R8");
        expect_at(b + 14, 1'b0, "R8"); expect_at(b + 17, 1'b0, "R8");
        expect_at(b + 20, 1'b0, "R8");
        expect_at(b + 38, 1'b0, "R8"); expect_at(b + 39, 1'b1, "R8");
        wait_to(b + 10); pad_in = 1'b1;
        wait_to(b + 14); pad_in = 1'b0;
        wait_to(b + 30); pad_in = 1'b1;
        drain();

        // R9: keep-high, N = 6
        set_cfg(2'b10, 4'd3, 2'b00);
        b = cyc;
        pad_in = 1'b0;
        expect_at(b + 4, 1'b1, "R9");  expect_at(b + 7, 1'b1, "R9");
        expect_at(b + 10, 1'b1, "R9");
        expect_at(b + 28, 1'b1, "R9"); expect_at(b + 29, 1'b0, "R9");
        expect_at(b + 42, 1'b0, "R9"); expect_at(b + 43, 1'b1, "R9");
        wait_to(b + 4);  pad_in = 1'b1;
        wait_to(b + 20); pad_in = 1'b0;
        wait_to(b + 40); pad_in = 1'b1;
        drain();

        // R10: no strobes, no progress (N = 4)
        set_cfg(2'b11, 4'd2, 2'b00);
        b = cyc;
        rtc_en = 1'b0;
        pad_in = 1'b0;
        expect_at(b + 10, 1'b1, "R10"); expect_at(b + 20, 1'b1, "R10");
        expect_at(b + 23, 1'b1, "R10"); expect_at(b + 24, 1'b0, "R10");
        wait_to(b + 20); rtc_en = 1'b1;
        drain();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule